// File: doc/BRIEF.md
# Multi-Mode Byte Multiplier with Flags

This block multiplies two bytes for a small RISC execution pipe. A 3-bit mode code chooses how each operand is read: both unsigned, both two's complement, or a signed first operand with an unsigned second one. A separate bit selects the integer or the fractional (Q-format) form of each of these. The block returns a 16-bit product, which the surrounding datapath writes to a fixed register pair: the low byte goes to the lower register and the high byte to the upper one. It also returns the two status bits that a multiply may change, Zero and Carry. All other status bits are left to the caller.

An operation begins with a one-cycle `start` pulse. The result, the flags and a one-cycle `done` pulse appear two clock cycles later. A new operation may be issued every second cycle. A `start` that arrives while an operation is still in its first stage is dropped. The product and flag outputs hold their values until the next `done`.

Top module: `mulx_unit`

## Requirements
- R1: Mode encoding. Bit 2 of `mode` selects the fractional form when 1. Bits 1:0 select operand signedness: 00 means both unsigned, 01 means both two's complement, 10 means `opa` two's complement and `opb` unsigned. The code 11 behaves exactly like 00.
- R2: In integer modes, `product` is the low 16 bits of the exact product of the operands as interpreted by R1 (for example, 0xFF×0xFF gives 0xFE01 unsigned, 0x0001 signed and 0xFF01 signed×unsigned).
- R3: In fractional modes, `product` is the integer product of R2 shifted left by one, keeping 16 bits. In signed fractional mode, 0x80×0x80 gives 0x8000.
- R4: `zero_flag` is 1 exactly when the returned 16-bit `product` (after any shift) is 0x0000.
- R5: `carry_flag` equals bit 15 of the unshifted integer product, in both integer and fractional modes.
- R6: When `start` is presented in the cycle before clock edge k and accepted, `done` is high for exactly one cycle, namely the cycle after edge k+1, and the result of that operation is on `product` and the flags during that cycle.
- R7: A `start` presented in the cycle directly after an accepted one is ignored. It produces no `done`, and the outputs keep the earlier operation's result.
- R8: Operations issued every second cycle are all accepted, and each one completes in order with its own result.
- R9: `product`, `zero_flag` and `carry_flag` change only in a cycle where `done` is high.
- R10: After reset, `done`, `product`, `zero_flag` and `carry_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiply |
| mode | input | 3 | Fractional select (bit 2) and signedness code (bits 1:0) |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| done | output | 1 | One-cycle pulse marking a fresh result |
| product | output | 16 | Result for the fixed register pair, low byte in bits 7:0 |
| zero_flag | output | 1 | Result equals zero |
| carry_flag | output | 1 | Bit 15 of the unshifted product |

## Verification
Two functions can meet in the same cycle. A new `start` can arrive while the previous operation is still in its first stage, and that same cycle is also when the result of the previous issue is being formed. The bench provokes this in two ways. Back-to-back issues every second cycle must each be accepted. A `start` one cycle after an accepted one must be dropped. The scoreboard judges both cases: any `done` with no queued expectation, or a `done` arriving on the wrong cycle, is a failure. The outputs after the dropped request must still equal the first operation's result.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

   // signedness code carried in the two low mode bits
   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_ALT = 2'b11
   } mulx_sign_e;

   typedef struct packed {
      logic       frac;
      mulx_sign_e sgn;
   } mulx_mode_t;

   function automatic logic first_is_signed(input mulx_sign_e s);
      return (s == SGN_SS) || (s == SGN_SU);
   endfunction

   function automatic logic second_is_signed(input mulx_sign_e s);
      return (s == SGN_SS);
   endfunction

endpackage

// File: rtl/mulx_opstage.sv
// First pipeline stage: captures operands and widens them by one bit
// so the array can treat every mode as a signed product.
module mulx_opstage
   import mulx_pkg::*;
#(
   parameter int W = 8,
   localparam int XW = W + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  mulx_mode_t    mode_in,
   input  logic [W-1:0]  a_in,
   input  logic [W-1:0]  b_in,
   output logic          s1_valid,
   output logic          s1_frac,
   output logic [XW-1:0] a_ext,
   output logic [XW-1:0] b_ext
);

   logic ext_a, ext_b;

   always_comb begin
      ext_a = first_is_signed(mode_in.sgn)  & a_in[W-1];
      ext_b = second_is_signed(mode_in.sgn) & b_in[W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_frac  <= 1'b0;
         a_ext    <= '0;
         b_ext    <= '0;
      end else begin
         s1_valid <= take;
         if (take) begin
            s1_frac <= mode_in.frac;
            a_ext   <= {ext_a, a_in};
            b_ext   <= {ext_b, b_in};
         end
      end
   end

endmodule

// File: rtl/mulx_array.sv
// Signed (W+1)x(W+1) partial-product array; the top row carries
// negative weight, the rest are summed.
module mulx_array #(
   parameter int W = 8,
   localparam int XW = W + 1,
   localparam int PW = 2 * XW,
   localparam int RW = 2 * W
)(
   input  logic [XW-1:0] a_ext,
   input  logic [XW-1:0] b_ext,
   output logic [RW-1:0] raw
);

   logic [PW-1:0] a_wide;
   logic [PW-1:0] rows [XW];
   logic [PW-1:0] total;

   assign a_wide = {{(PW-XW){a_ext[XW-1]}}, a_ext};

   for (genvar i = 0; i < XW; i++) begin : g_row
      assign rows[i] = b_ext[i] ? (a_wide << i) : '0;
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < XW - 1; i++) begin
         total = total + rows[i];
      end
      total = total - rows[XW-1];
   end

   assign raw = total[RW-1:0];

endmodule

// File: rtl/mulx_post.sv
// Second stage: optional one-bit left shift, flag derivation, output
// registers and the completion pulse.
module mulx_post #(
   parameter int W = 8,
   localparam int RW = 2 * W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s1_valid,
   input  logic          s1_frac,
   input  logic [RW-1:0] raw,
   output logic          done,
   output logic [RW-1:0] result,
   output logic          z_out,
   output logic          c_out
);

   logic [RW-1:0] shaped;

   always_comb begin
      shaped = s1_frac ? {raw[RW-2:0], 1'b0} : raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
         z_out  <= 1'b0;
         c_out  <= 1'b0;
      end else begin
         done <= s1_valid;
         if (s1_valid) begin
            result <= shaped;
            z_out  <= (shaped == '0);
            c_out  <= raw[RW-1];
         end
      end
   end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
   import mulx_pkg::*;
#(
   parameter int W = 8,
   localparam int XW = W + 1,
   localparam int RW = 2 * W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [2:0]    mode,
   input  logic [W-1:0]  opa,
   input  logic [W-1:0]  opb,
   output logic          done,
   output logic [RW-1:0] product,
   output logic          zero_flag,
   output logic          carry_flag
);

   if (W < 2) begin : g_bad_width
      $error("mulx_unit: W must be at least 2");
   end

   logic          take;
   logic          s1_valid;
   logic          s1_frac;
   logic [XW-1:0] a_ext;
   logic [XW-1:0] b_ext;
   logic [RW-1:0] raw;
   mulx_mode_t    mode_s;

   assign mode_s = mulx_mode_t'(mode);
   // stage one occupied means the request is dropped
   assign take   = start & ~s1_valid;

   mulx_opstage #(.W(W)) u_op (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .mode_in  (mode_s),
      .a_in     (opa),
      .b_in     (opb),
      .s1_valid (s1_valid),
      .s1_frac  (s1_frac),
      .a_ext    (a_ext),
      .b_ext    (b_ext)
   );

   mulx_array #(.W(W)) u_arr (
      .a_ext (a_ext),
      .b_ext (b_ext),
      .raw   (raw)
   );

   mulx_post #(.W(W)) u_post (
      .clk      (clk),
      .rst_n    (rst_n),
      .s1_valid (s1_valid),
      .s1_frac  (s1_frac),
      .raw      (raw),
      .done     (done),
      .result   (product),
      .z_out    (zero_flag),
      .c_out    (carry_flag)
   );

endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
   parameter int W = 8,
   localparam int RW = 2 * W
)(
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [2:0]    mode,
   input logic          done,
   input logic [RW-1:0] product,
   input logic          zero_flag,
   input logic          carry_flag
);

   AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start, 2));                                      // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R7

   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(product) || done));                          // R9

   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (zero_flag == (product == '0)));                       // R4

   AST_INT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(mode[2], 2)) |-> (carry_flag == product[RW-1])); // R5

endmodule

bind mulx_unit mulx_unit_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mode       (mode),
   .done       (done),
   .product    (product),
   .zero_flag  (zero_flag),
   .carry_flag (carry_flag)
);

// File: tb/sim_mulx_unit.sv
module sim_mulx_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          due;
      logic [15:0] prod;
      logic        z;
      logic        c;
      string       tag;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start = 0;
   logic [2:0]  mode = 0;
   logic [7:0]  opa = 0;
   logic [7:0]  opb = 0;
   logic        done;
   logic [15:0] product;
   logic        zero_flag;
   logic        carry_flag;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 0;
   exp_t q[$];

   mulx_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .opa(opa), .opb(opb), .done(done), .product(product),
      .zero_flag(zero_flag), .carry_flag(carry_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // reference model from the requirements: integer arithmetic
   function automatic exp_t model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
      exp_t e;
      int va, vb, p;
      logic [15:0] rawp;
      va = ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a[7]) ? int'(a) - 256 : int'(a);
      vb = (m[1:0] == 2'b01 && b[7]) ? int'(b) - 256 : int'(b);
      p = va * vb;
      rawp = p[15:0];
      e.prod = m[2] ? {rawp[14:0], 1'b0} : rawp;
      e.c = rawp[15];
      e.z = (e.prod == 16'h0000);
      return e;
   endfunction

   task automatic issue(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input string tag);
      exp_t e;
      @(negedge clk);
      mode = m; opa = a; opb = b; start = 1;
      e = model(m, a, b);
      e.due = cyc + 2;
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      start = 0;
   endtask

   // monitor: pops and compares each completion
   initial begin
      logic [15:0] prev;
      prev = 0;
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (!done) begin
               chk(product == prev, "R9 hold", product, prev);
            end else if (q.size() == 0) begin
               chk(0, "R7 unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc == e.due, {"R6 latency ", e.tag}, cyc, e.due);
               chk(product == e.prod, {"R2/R3 product ", e.tag}, product, e.prod);
               chk(zero_flag == e.z, {"R4 zero ", e.tag}, zero_flag, e.z);
               chk(carry_flag == e.c, {"R5 carry ", e.tag}, carry_flag, e.c);
            end
            prev = product;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(0, "watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(done == 0 && product == 0 && zero_flag == 0 && carry_flag == 0,
          "R10 reset state", {done, zero_flag, carry_flag, product}, 0);

      // R1 R2 R3 R5: 0xFF x 0xFF in all eight codes, code 3/7 alias unsigned
      for (int m = 0; m < 8; m++) issue(3'(m), 8'hFF, 8'hFF, "R1 all-ones");
      chk(model(3'd1, 8'hFF, 8'hFF).prod == 16'h0001, "R2 model signed", 0, 1);
      // R3 signed fractional -1.0 x -1.0 wraps
      issue(3'b101, 8'h80, 8'h80, "R3 frac wrap 0x8000");
      // R4 zero results
      issue(3'b000, 8'h00, 8'h37, "R4 zero uu");
      issue(3'b110, 8'h9A, 8'h00, "R4 zero frac su");
      // R1 signed x unsigned distinction
      issue(3'b010, 8'h80, 8'hFF, "R1 su min");
      issue(3'b001, 8'h80, 8'h7F, "R1 ss");
      issue(3'b100, 8'h80, 8'h80, "R3 frac uu");
      issue(3'b011, 8'h80, 8'hFF, "R1 alias 11");

      // R8 back-to-back every second cycle, random patterns
      for (int i = 0; i < 300; i++) begin
         issue(3'($urandom), 8'($urandom), 8'($urandom), "R8 stream");
      end
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R8 all completed", q.size(), 0);

      // R7 start while busy is dropped
      issue(3'b001, 8'h05, 8'h07, "R7 first");
      // issue() returned at the negedge after the accepted start; back up:
      // drive a pair where the second start lands on the busy cycle
      repeat (4) @(negedge clk);
      begin
         exp_t e;
         mode = 3'b000; opa = 8'h11; opb = 8'h03; start = 1;
         e = model(3'b000, 8'h11, 8'h03);
         e.due = cyc + 2; e.tag = "R7 accepted";
         q.push_back(e);
         @(negedge clk);
         mode = 3'b000; opa = 8'hEE; opb = 8'hEE; start = 1;  // dropped
         @(negedge clk);
         start = 0;
      end
      repeat (6) @(negedge clk);
      held = 16'h0033;
      chk(product == held, "R7 outputs after dropped start", product, held);
      chk(q.size() == 0, "R7 queue drained", q.size(), 0);

      // R9 idle hold
      repeat (10) @(negedge clk);
      chk(product == held, "R9 idle hold", product, held);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule